// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Run-Time Preload

This block multiplies an A_W-bit operand by a B_W-bit operand and folds the product into a running sum that is A_W+B_W+16 bits wide. Each clock it either adds or subtracts the product, and a load control can instead replace the sum with an external preload value. Each operand has its own signedness control. The sum and an overflow flag leave the block from registers.

Each operand is taken from a parallel data port or from a serial-chain port. The operand that was picked is driven back out on a shift-out port, so that a neighbouring unit can take it as its own serial-chain input. Two parameters each add a register stage: one on the inputs and one after the multiplier. The sign, add/subtract and load controls and the preload value pass through the same stages as the operands, so they stay aligned with their data. A clock enable freezes the whole datapath. A synchronous active-low reset clears it.

Top module: `mac_preload`

## Requirements
- R1: On every enabled edge the sum register takes the previous sum plus the product of the operands. The operands reach the sum after USE_IN_REG + USE_PIPE_REG + 1 enabled edges.
- R2: When `sub` is 1, the product is subtracted from the sum instead of being added.
- R3: `a_signed` makes A a two's-complement value and `b_signed` does the same for B; a low flag makes that operand unsigned. If either flag is set, the sum is treated as signed. Otherwise it is treated as unsigned.
- R4: When `load` is 1, the sum takes `preload` and the overflow flag clears on the same edge.
- R5: In signed treatment, `ovf_out` is 1 for the one result whose true signed value lies outside the signed range of the sum width.
- R6: In unsigned treatment, `ovf_out` is 1 for a result that produces a carry out of an add or a borrow out of a subtract.
- R7: USE_IN_REG and USE_PIPE_REG each add one register stage. The controls and the preload value are delayed by the same stages as the operands.
- R8: `a_sel`/`b_sel` = 1 picks `a_sin`/`b_sin`, and 0 picks `a_par`/`b_par`. The port that is not picked has no effect.
- R9: `a_sout`/`b_sout` carry the input-stage register content when USE_IN_REG = 1. When USE_IN_REG = 0 they carry the picked operand directly.
- R10: While `ce` is 0, no register changes, and a `load` presented in that time is not taken.
- R11: A clock edge with `rst_n` low clears every stage, the sum and the overflow flag to zero, whatever the state of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable for every stage |
| a_par | input | A_W | Parallel operand A |
| a_sin | input | A_W | Serial-chain operand A |
| a_sel | input | 1 | 1 picks a_sin, 0 picks a_par |
| b_par | input | B_W | Parallel operand B |
| b_sin | input | B_W | Serial-chain operand B |
| b_sel | input | 1 | 1 picks b_sin, 0 picks b_par |
| a_signed | input | 1 | Operand A is two's complement |
| b_signed | input | 1 | Operand B is two's complement |
| sub | input | 1 | Subtract the product instead of adding it |
| load | input | 1 | Replace the sum with preload |
| preload | input | A_W+B_W+16 | Value taken on load |
| a_sout | output | A_W | Operand A passed on down the chain |
| b_sout | output | B_W | Operand B passed on down the chain |
| acc_out | output | A_W+B_W+16 | Registered sum |
| ovf_out | output | 1 | Registered overflow flag |

## Verification
All four register-stage configurations receive the same stimulus side by side. This separates latency and control-alignment faults from arithmetic faults. The patterns are:
- Runs that only add and runs that mix add and subtract, to tell the subtract path apart from the add path.
- All four sign-mode pairs, first held steady and then changed every cycle, to expose controls that slip out of step with their operands.
- Preloads set just inside the signed and unsigned limits and then pushed past them with large products, to separate signed overflow from carry and borrow.
- Runs with the serial ports picked, with random values on the ports that are not picked.
- Stalls of the clock enable that carry a load.
- A random soak that mixes stalls, loads and a reset issued mid-run.

// File: rtl/mac_pkg.sv
// Shared types of the multiply-accumulate unit.
// Assumes: controls are travelling alongside operands through every stage.
package mac_pkg;

    // Per-operation control word that moves with its operands (R7).
    typedef struct packed {
        logic a_signed;
        logic b_signed;
        logic sub;
        logic load;
    } mac_ctrl_t;

    localparam int CTRL_W = 4;

    // Width of the running sum for given operand widths.
    function automatic int sum_width(input int aw, input int bw);
        return aw + bw + 16;
    endfunction

endpackage

// File: rtl/mac_stage_reg.sv
// Optional pipeline register of W bits.
// EN = 1 builds a register with synchronous active-low clear and an enable.
// EN = 0 builds a plain wire. Assumes that the caller packs all fields of
// one stage into d, so that they move together.
module mac_stage_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (EN) begin : g_reg
            logic [W-1:0] r;
            // Capture the stage contents on enabled edges; reset wins over ce (R10, R11).
            always_ff @(posedge clk) begin
                if (!rst_n)  r <= '0;
                else if (ce) r <= d;
            end
            assign q = r;
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mac_product.sv
// Combinational multiplier with a signedness control on each operand.
// Each operand is widened by one bit: the extra bit is a copy of the sign
// when the operand is signed and zero when it is not. The result keeps the
// low A_W+B_W bits. Every mix of signedness fits in that width (R3).
module mac_product #(
    parameter int A_W = 9,
    parameter int B_W = 9,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic           a_signed,
    input  logic           b_signed,
    output logic [P_W-1:0] prod
);

    logic signed [A_W:0]   a_x;
    logic signed [B_W:0]   b_x;
    logic signed [P_W-1:0] a_w;
    logic signed [P_W-1:0] b_w;
    logic signed [P_W-1:0] p_w;

    // Extend both operands to the product width by their own mode, then multiply.
    always_comb begin
        a_x  = {a_signed & a[A_W-1], a};
        b_x  = {b_signed & b[B_W-1], b};
        a_w  = P_W'(a_x);
        b_w  = P_W'(b_x);
        p_w  = a_w * b_w;
        prod = p_w;
    end

endmodule

// File: rtl/mac_accum.sv
// Sum register with add/subtract, preload and overflow detection.
// The sum is kept one bit wider inside so the true result can be judged.
// Signed treatment flags a change of sign past the range (R5). Unsigned
// treatment flags a carry or borrow (R6). A load takes the preload value
// and clears the flag (R4).
module mac_accum #(
    parameter int P_W   = 18,
    parameter int ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [P_W-1:0]   prod,
    input  logic             signed_mode,
    input  logic             sub,
    input  logic             load,
    input  logic [ACC_W-1:0] pre,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);

    localparam int EXT = ACC_W + 1 - P_W;

    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;
    logic [ACC_W:0]   acc_x;
    logic [ACC_W:0]   prod_x;
    logic [ACC_W:0]   sum_x;
    logic             ovf_nxt;

    // Form the widened add or subtract and judge overflow by treatment (R1, R2).
    always_comb begin
        acc_x   = {signed_mode & acc_q[ACC_W-1], acc_q};
        prod_x  = {{EXT{signed_mode & prod[P_W-1]}}, prod};
        sum_x   = sub ? (acc_x - prod_x) : (acc_x + prod_x);
        ovf_nxt = signed_mode ? (sum_x[ACC_W] ^ sum_x[ACC_W-1]) : sum_x[ACC_W];
    end

    // Register the sum and flag together; load overrides, ce freezes, reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (ce) begin
            if (load) begin
                acc_q <= pre;
                ovf_q <= 1'b0;
            end else begin
                acc_q <= sum_x[ACC_W-1:0];
                ovf_q <= ovf_nxt;
            end
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/mac_preload.sv
// Multiply-accumulate unit, top level.
// Operand pick -> optional input stage -> multiplier -> optional pipeline
// stage -> sum register. Controls and preload travel in the same stage words
// as the operands (R7). The shift-out ports show the input stage (R9).
// Assumes a single clock domain and synchronous active-low reset.
module mac_preload
    import mac_pkg::*;
#(
    parameter int A_W          = 9,
    parameter int B_W          = 9,
    parameter bit USE_IN_REG   = 1'b1,
    parameter bit USE_PIPE_REG = 1'b1,
    localparam int ACC_W       = A_W + B_W + 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [A_W-1:0]   a_par,
    input  logic [A_W-1:0]   a_sin,
    input  logic             a_sel,
    input  logic [B_W-1:0]   b_par,
    input  logic [B_W-1:0]   b_sin,
    input  logic             b_sel,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             sub,
    input  logic             load,
    input  logic [ACC_W-1:0] preload,
    output logic [A_W-1:0]   a_sout,
    output logic [B_W-1:0]   b_sout,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf_out
);

    localparam int P_W    = A_W + B_W;
    localparam int IN_W   = A_W + B_W + CTRL_W + ACC_W;
    localparam int PIPE_W = P_W + 3 + ACC_W;

    logic [A_W-1:0]   a_pick;
    logic [B_W-1:0]   b_pick;
    mac_ctrl_t        ctrl_in;
    logic [IN_W-1:0]  in_d;
    logic [IN_W-1:0]  in_q;
    logic [A_W-1:0]   a_r;
    logic [B_W-1:0]   b_r;
    mac_ctrl_t        ctrl_r;
    logic [ACC_W-1:0] pre_r;
    logic [P_W-1:0]   prod;
    logic [PIPE_W-1:0] pipe_d;
    logic [PIPE_W-1:0] pipe_q;
    logic [P_W-1:0]   stg_prod;
    logic             stg_smode;
    logic             stg_sub;
    logic             stg_load;
    logic [ACC_W-1:0] stg_pre;

    // Pick each operand source and pack the input stage word (R8).
    always_comb begin
        a_pick           = a_sel ? a_sin : a_par;
        b_pick           = b_sel ? b_sin : b_par;
        ctrl_in.a_signed = a_signed;
        ctrl_in.b_signed = b_signed;
        ctrl_in.sub      = sub;
        ctrl_in.load     = load;
        in_d             = {a_pick, b_pick, ctrl_in, preload};
    end

    mac_stage_reg #(.W(IN_W), .EN(USE_IN_REG)) u_in_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     (in_d),
        .q     (in_q)
    );

    // Unpack the input stage and pass the operands down the chain (R9).
    always_comb begin
        {a_r, b_r, ctrl_r, pre_r} = in_q;
        a_sout = a_r;
        b_sout = b_r;
    end

    mac_product #(.A_W(A_W), .B_W(B_W)) u_mul (
        .a        (a_r),
        .b        (b_r),
        .a_signed (ctrl_r.a_signed),
        .b_signed (ctrl_r.b_signed),
        .prod     (prod)
    );

    // Pack the pipeline stage word; signed treatment if either operand is signed (R3).
    always_comb begin
        pipe_d = {prod, ctrl_r.a_signed | ctrl_r.b_signed, ctrl_r.sub, ctrl_r.load, pre_r};
    end

    mac_stage_reg #(.W(PIPE_W), .EN(USE_PIPE_REG)) u_pipe_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     (pipe_d),
        .q     (pipe_q)
    );

    // Unpack the pipeline stage for the sum register.
    always_comb begin
        {stg_prod, stg_smode, stg_sub, stg_load, stg_pre} = pipe_q;
    end

    mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (ce),
        .prod        (stg_prod),
        .signed_mode (stg_smode),
        .sub         (stg_sub),
        .load        (stg_load),
        .pre         (stg_pre),
        .acc         (acc_out),
        .ovf         (ovf_out)
    );

endmodule

// File: rtl/mac_preload_chk.sv
// Assertion checker for mac_preload, attached by bind.
// Observes the ports and the load/preload word that reaches the sum register.
module mac_preload_chk #(
    parameter int A_W        = 9,
    parameter int B_W        = 9,
    parameter bit USE_IN_REG = 1'b1,
    parameter int ACC_W      = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic [A_W-1:0]   a_par,
    input logic [A_W-1:0]   a_sin,
    input logic             a_sel,
    input logic [B_W-1:0]   b_par,
    input logic [B_W-1:0]   b_sin,
    input logic             b_sel,
    input logic [A_W-1:0]   a_sout,
    input logic [B_W-1:0]   b_sout,
    input logic [ACC_W-1:0] acc_out,
    input logic             ovf_out,
    input logic             stg_load,
    input logic [ACC_W-1:0] stg_pre
);

    // R11: a reset edge leaves the sum and the flag at zero.
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && !ovf_out));

    // R10: a stalled edge changes neither output register.
    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(acc_out) && $stable(ovf_out)));

    // R4: a load reaching the sum register takes the preload and clears the flag.
    assert_load_takes_preload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && stg_load) |=> (acc_out == $past(stg_pre) && !ovf_out));

    generate
        if (USE_IN_REG) begin : g_reg_chain
            // R9: the shift-out shows the operand picked at the last enabled edge.
            assert_sout_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ce |=> (a_sout == $past(a_sel ? a_sin : a_par)));
            assert_sout_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ce |=> (b_sout == $past(b_sel ? b_sin : b_par)));
        end else begin : g_wire_chain
            // R8: with no input stage the shift-out follows the picked source.
            assert_pick_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
                a_sout == (a_sel ? a_sin : a_par));
            assert_pick_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
                b_sout == (b_sel ? b_sin : b_par));
        end
    endgenerate

endmodule

bind mac_preload mac_preload_chk #(
    .A_W        (A_W),
    .B_W        (B_W),
    .USE_IN_REG (USE_IN_REG),
    .ACC_W      (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .a_par    (a_par),
    .a_sin    (a_sin),
    .a_sel    (a_sel),
    .b_par    (b_par),
    .b_sin    (b_sin),
    .b_sel    (b_sel),
    .a_sout   (a_sout),
    .b_sout   (b_sout),
    .acc_out  (acc_out),
    .ovf_out  (ovf_out),
    .stg_load (stg_load),
    .stg_pre  (stg_pre)
);

// File: tb/mac_preload_tb.sv
`timescale 1ns/1ps
// Bench: all four stage configurations run side by side against a
// behavioural model that uses 64-bit integers and a queue for latency.
module mac_preload_tb_top;

    typedef struct packed {
        logic [8:0]  a;
        logic [8:0]  b;
        logic        sa;
        logic        sb;
        logic        sub;
        logic        load;
        logic [33:0] pre;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic [8:0]  a_par = '0, a_sin = '0, b_par = '0, b_sin = '0;
    logic        a_sel = 1'b0, b_sel = 1'b0;
    logic        s_a = 1'b0, s_b = 1'b0, sub_r = 1'b0, load_r = 1'b0;
    logic [33:0] pre_r = '0;
    string       cur_tag = "R11";
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int cfg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cfg%0d actual=%h expected=%h", tag, what, cfg, act, exp);
        end
    endtask

    function automatic rec_t cur_rec();
        rec_t r;
        r.a    = a_sel ? a_sin : a_par;
        r.b    = b_sel ? b_sin : b_par;
        r.sa   = s_a;
        r.sb   = s_b;
        r.sub  = sub_r;
        r.load = load_r;
        r.pre  = pre_r;
        return r;
    endfunction

    // Reference step: returns {ovf, new sum} from the requirements R1-style rules.
    function automatic logic [34:0] ref_step(input logic [33:0] acc, input rec_t f);
        longint pa, pb, av, t;
        bit     sm, ov;
        if (f.load) return {1'b0, f.pre};
        pa = longint'(f.a);
        pb = longint'(f.b);
        if (f.sa && f.a[8]) pa -= 512;
        if (f.sb && f.b[8]) pb -= 512;
        sm = f.sa | f.sb;
        av = longint'(acc);
        if (sm && acc[33]) av -= 64'sd17179869184;
        t = f.sub ? av - pa * pb : av + pa * pb;
        if (sm) ov = (t < -64'sd8589934592) || (t > 64'sd8589934591);
        else    ov = (t < 0) || (t > 64'sd17179869183);
        return {ov, t[33:0]};
    endfunction

    for (genvar k = 0; k < 4; k++) begin : g_cfg
        localparam bit IN_E   = k[0];
        localparam bit PIPE_E = k[1];
        localparam int L      = int'(IN_E) + int'(PIPE_E);

        logic [8:0]  a_so, b_so;
        logic [33:0] acc_o;
        logic        ovf_o;

        mac_preload #(.A_W(9), .B_W(9), .USE_IN_REG(IN_E), .USE_PIPE_REG(PIPE_E)) dut_i (
            .clk(clk), .rst_n(rst_n), .ce(ce),
            .a_par(a_par), .a_sin(a_sin), .a_sel(a_sel),
            .b_par(b_par), .b_sin(b_sin), .b_sel(b_sel),
            .a_signed(s_a), .b_signed(s_b), .sub(sub_r), .load(load_r),
            .preload(pre_r), .a_sout(a_so), .b_sout(b_so),
            .acc_out(acc_o), .ovf_out(ovf_o)
        );

        rec_t        q[$];
        logic [33:0] m_acc = '0;
        bit          m_ovf = 1'b0;
        logic [8:0]  m_as = '0, m_bs = '0;

        // Model: reset wins (R11), stall holds (R10), else delay by L and step (R7).
        always @(posedge clk) begin
            rec_t r, f;
            logic [34:0] nx;
            if (!rst_n) begin
                m_acc = '0; m_ovf = 1'b0; m_as = '0; m_bs = '0;
                q.delete();
                for (int i = 0; i < L; i++) q.push_back(rec_t'(0));
            end else if (ce) begin
                r = cur_rec();
                q.push_back(r);
                f = q.pop_front();
                nx = ref_step(m_acc, f);
                m_ovf = nx[34];
                m_acc = nx[33:0];
                m_as = r.a;
                m_bs = r.b;
            end
        end

        // Compare on every falling edge; shift-out per R9.
        always @(negedge clk) begin
            logic [8:0] ea, eb;
            if (!finished) begin
                ea = IN_E ? m_as : (a_sel ? a_sin : a_par);
                eb = IN_E ? m_bs : (b_sel ? b_sin : b_par);
                chk(acc_o === m_acc, cur_tag, "sum", k, longint'(acc_o), longint'(m_acc));
                chk(ovf_o === m_ovf, cur_tag, "ovf", k, longint'(ovf_o), longint'(m_ovf));
                chk(a_so === ea, "R9", "a_sout", k, longint'(a_so), longint'(ea));
                chk(b_so === eb, "R9", "b_sout", k, longint'(b_so), longint'(eb));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic op(input logic [8:0] a, input logic [8:0] b,
                      input bit sa, input bit sb, input bit sb_sub);
        a_par = a; b_par = b; s_a = sa; s_b = sb; sub_r = sb_sub; load_r = 1'b0;
        a_sin = 9'($urandom); b_sin = 9'($urandom); pre_r = 34'({$urandom, $urandom});
        tick();
    endtask

    task automatic do_load(input logic [33:0] v, input bit sa, input bit sb);
        pre_r = v; load_r = 1'b1; s_a = sa; s_b = sb;
        tick();
        load_r = 1'b0;
    endtask

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1: unsigned accumulate only
        cur_tag = "R1";
        repeat (20) op(9'($urandom), 9'($urandom), 0, 0, 0);
        // R2: mixed add and subtract
        cur_tag = "R2";
        repeat (20) op(9'($urandom), 9'($urandom), 0, 0, 1'($urandom));
        // R3: every sign pair held, then changing every cycle
        cur_tag = "R3";
        for (int m = 0; m < 4; m++)
            repeat (8) op(9'($urandom), 9'($urandom), m[0], m[1], 1'($urandom));
        repeat (24) op(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        // R4: preload mid-stream, also back to back
        cur_tag = "R4";
        repeat (4) op(9'($urandom), 9'($urandom), 1, 0, 0);
        do_load(34'h1_2345_6789, 1, 0);
        repeat (4) op(9'($urandom), 9'($urandom), 1, 0, 1);
        do_load(34'h0_0000_0100, 0, 0);
        do_load(34'h3_FFFF_FF00, 1, 1);
        repeat (4) op(9'($urandom), 9'($urandom), 0, 1, 0);
        // R5: signed overflow near both limits
        cur_tag = "R5";
        do_load(34'h1_FFFF_FF00, 1, 1);
        repeat (3) op(9'h0FF, 9'h0FF, 1, 1, 0);
        do_load(34'h2_0000_0032, 1, 1);
        repeat (3) op(9'h0FF, 9'h0FF, 1, 1, 1);
        do_load(34'h2_0000_0010, 1, 0);
        repeat (3) op(9'h100, 9'h1FF, 1, 0, 0);
        // R6: unsigned carry and borrow
        cur_tag = "R6";
        do_load(34'h3_FFFF_FF9C, 0, 0);
        repeat (3) op(9'h1FF, 9'h1FF, 0, 0, 0);
        do_load(34'h0_0000_0032, 0, 0);
        repeat (3) op(9'h0FF, 9'h0FF, 0, 0, 1);
        // R8: serial sources picked, unpicked ports randomised
        cur_tag = "R8";
        repeat (24) begin
            a_sel = 1'($urandom); b_sel = 1'($urandom);
            op(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        a_sel = 1'b0; b_sel = 1'b0;
        // R10: stall with changing inputs and a load
        cur_tag = "R10";
        ce = 1'b0;
        repeat (3) op(9'($urandom), 9'($urandom), 1, 1, 0);
        do_load(34'h0_DEAD_BEEF, 0, 0);
        repeat (3) op(9'($urandom), 9'($urandom), 0, 0, 1);
        ce = 1'b1;
        repeat (6) op(9'($urandom), 9'($urandom), 0, 0, 0);
        // R7: random soak across all configurations
        cur_tag = "R7";
        repeat (400) begin
            ce = ($urandom % 8) != 0;
            a_sel = 1'($urandom); b_sel = 1'($urandom);
            if (($urandom % 16) == 0) do_load(34'({$urandom, $urandom}), 1'($urandom), 1'($urandom));
            else op(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        // R11: reset mid-run with ce low
        cur_tag = "R11";
        ce = 1'b0;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1; ce = 1'b1;
        repeat (8) op(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule